// File: doc/BRIEF.md
# Pin-Sequence Mode Switch Detector

This block sits next to a serial LED sink driver core. It decides whether the core runs in normal display mode or in fault-detection mode. The same two pins that carry the output-enable and latch-enable levels also carry the mode commands. The block samples both levels on every rising clock edge and keeps the most recent samples in a short history window. It compares the whole window against two five-step patterns on every edge: one that enters detection mode and one that returns to normal mode.

A command is only accepted if it leads to the other mode. An entry pattern seen while already in detection mode is dropped, and so is a resume pattern seen while already in normal mode. The detection flag therefore alternates strictly between entry and resume. When a command is accepted, a one-cycle pulse marks the change and the history is wiped. Samples that belonged to the accepted command can then never count toward the next one. The core reads the flag from the sixth edge on to decide what the serial input means.

Top module: `modesw_detector`

## Requirements
- R1: While `rst_n` is low, and on the first edges after it is released, `detect_mode` is 0 and `mode_pulse` is 0.
- R2: In normal mode, five consecutive rising edges with (`oe_pin`,`le_pin`) equal to (1,0),(0,0),(1,0),(1,1),(1,0), oldest first, set `detect_mode` to 1 after the fifth edge. The flag is therefore seen as 1 from the sixth edge.
- R3: In detection mode, five consecutive edges with (1,0),(0,0),(1,0),(1,0),(1,0) return `detect_mode` to 0 after the fifth edge.
- R4: `mode_pulse` is 1 for exactly the one cycle after the edge that completes an accepted pattern. At all other times it is 0, and `detect_mode` changes only in that cycle.
- R5: The entry pattern of R2 has no effect in detection mode: no pulse, and the flag stays 1.
- R6: The resume pattern of R3 has no effect in normal mode: no pulse, and the flag stays 0.
- R7: The window is compared on every edge. A pattern whose first steps overlap an earlier, abandoned attempt is still recognised.
- R8: Reset and every accepted change clear the history. A new command then needs five fresh samples taken after the change, even when the last sample of the previous command would complete it.
- R9: After a resume, a later entry pattern enters detection mode again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; both levels are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_pin | input | 1 | Output-enable pin level (1 = high) |
| le_pin | input | 1 | Latch-enable pin level (1 = high) |
| detect_mode | output | 1 | 1 while in fault-detection mode |
| mode_pulse | output | 1 | One-cycle marker of an accepted mode change |

## Verification
The hardest case to reach is a stale window. This is a case where the sample that finished one command, together with four new samples, would form the opposite command. Only the clear-after-match rule keeps such a window from flipping the mode. The stimulus enters detection mode and then supplies exactly the four resume samples that would complete such a window. It expects no change. Overlapping recognition is reached by breaking off a first entry attempt after its third step, so that the real pattern starts inside it.

// File: rtl/modesw_pkg.sv
package modesw_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DETECT = 1'b1
  } mode_e;

  // One window step equals one pattern step when both levels agree.
  function automatic logic step_eq(input logic s_oe, input logic s_le,
                                   input logic p_oe, input logic p_le);
    return (s_oe == p_oe) && (s_le == p_le);
  endfunction

  // Next mode after an accepted toggle.
  function automatic mode_e flip_mode(input mode_e m);
    return (m == MODE_NORMAL) ? MODE_DETECT : MODE_NORMAL;
  endfunction

endpackage

// File: rtl/modesw_history.sv
module modesw_history #(
  parameter int   DEPTH  = 5,
  parameter logic CLR_OE = 1'b0,
  parameter logic CLR_LE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_oe,
  input  logic             cur_le,
  input  logic             clear,
  output logic [DEPTH-1:0] win_oe,
  output logic [DEPTH-1:0] win_le
);
  localparam int STORED = DEPTH - 1;

  // Index 0 holds the previous sample; higher indices are older.
  logic [STORED-1:0] st_oe;
  logic [STORED-1:0] st_le;

  genvar k;
  generate
    for (k = 0; k < STORED; k++) begin : g_stage
      logic nxt_oe;
      logic nxt_le;
      if (k == 0) begin : g_head
        assign nxt_oe = cur_oe;
        assign nxt_le = cur_le;
      end else begin : g_body
        assign nxt_oe = st_oe[k-1];
        assign nxt_le = st_le[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_oe[k] <= CLR_OE;
          st_le[k] <= CLR_LE;
        end else if (clear) begin
          st_oe[k] <= CLR_OE;
          st_le[k] <= CLR_LE;
        end else begin
          st_oe[k] <= nxt_oe;
          st_le[k] <= nxt_le;
        end
      end
    end
  endgenerate

  // Window bit 0 is the level at the current edge and bit DEPTH-1 is the oldest.
  assign win_oe = {st_oe, cur_oe};
  assign win_le = {st_le, cur_le};
endmodule

// File: rtl/modesw_matcher.sv
module modesw_matcher
  import modesw_pkg::*;
#(
  parameter int             DEPTH  = 5,
  parameter logic [DEPTH-1:0] PAT_OE = 5'b10111,
  parameter logic [DEPTH-1:0] PAT_LE = 5'b00010
) (
  input  logic [DEPTH-1:0] win_oe,
  input  logic [DEPTH-1:0] win_le,
  output logic             hit
);
  // Pattern MSB is the first step in time and lines up with the oldest window bit.
  logic [DEPTH-1:0] eq;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_cmp
      assign eq[i] = step_eq(win_oe[i], win_le[i], PAT_OE[i], PAT_LE[i]);
    end
  endgenerate

  assign hit = &eq;
endmodule

// File: rtl/modesw_fsm.sv
module modesw_fsm
  import modesw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic entry_hit,
  input  logic resume_hit,
  output logic accept_chg,
  output logic detect_mode,
  output logic mode_pulse
);
  mode_e mode_q;
  logic  pulse_q;
  logic  take_entry;
  logic  take_resume;

  // Each command is only honoured when it leads to the other mode.
  assign take_entry  = entry_hit  && (mode_q == MODE_NORMAL);
  assign take_resume = resume_hit && (mode_q == MODE_DETECT);
  assign accept_chg  = take_entry || take_resume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= accept_chg;
      if (accept_chg) mode_q <= flip_mode(mode_q);
    end
  end

  assign detect_mode = (mode_q == MODE_DETECT);
  assign mode_pulse  = pulse_q;
endmodule

// File: rtl/modesw_detector.sv
module modesw_detector #(
  parameter int               SEQ_LEN   = 5,
  parameter logic [SEQ_LEN-1:0] ENTER_OE  = 5'b10111,
  parameter logic [SEQ_LEN-1:0] ENTER_LE  = 5'b00010,
  parameter logic [SEQ_LEN-1:0] RESUME_OE = 5'b10111,
  parameter logic [SEQ_LEN-1:0] RESUME_LE = 5'b00000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_pin,
  input  logic le_pin,
  output logic detect_mode,
  output logic mode_pulse
);
  // The fill value is the opposite of the entry pattern's first step.
  // Both patterns share that first step, so a cleared window matches neither.
  localparam logic FILL_OE = ~ENTER_OE[SEQ_LEN-1];
  localparam logic FILL_LE = ~ENTER_LE[SEQ_LEN-1];

  logic [SEQ_LEN-1:0] win_oe;
  logic [SEQ_LEN-1:0] win_le;
  logic entry_hit;
  logic resume_hit;
  logic accept_chg;

  modesw_history #(
    .DEPTH (SEQ_LEN),
    .CLR_OE(FILL_OE),
    .CLR_LE(FILL_LE)
  ) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_oe(oe_pin),
    .cur_le(le_pin),
    .clear (accept_chg),
    .win_oe(win_oe),
    .win_le(win_le)
  );

  modesw_matcher #(
    .DEPTH (SEQ_LEN),
    .PAT_OE(ENTER_OE),
    .PAT_LE(ENTER_LE)
  ) u_enter (
    .win_oe(win_oe),
    .win_le(win_le),
    .hit   (entry_hit)
  );

  modesw_matcher #(
    .DEPTH (SEQ_LEN),
    .PAT_OE(RESUME_OE),
    .PAT_LE(RESUME_LE)
  ) u_resume (
    .win_oe(win_oe),
    .win_le(win_le),
    .hit   (resume_hit)
  );

  modesw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_hit  (entry_hit),
    .resume_hit (resume_hit),
    .accept_chg (accept_chg),
    .detect_mode(detect_mode),
    .mode_pulse (mode_pulse)
  );
endmodule

// File: rtl/modesw_detector_chk.sv
module modesw_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic entry_hit,
  input logic resume_hit,
  input logic detect_mode,
  input logic mode_pulse
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pulse |=> !mode_pulse); // R4
  AST_PULSE_MARKS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pulse |-> (detect_mode != $past(detect_mode))); // R4
  AST_NO_SILENT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_pulse |-> $stable(detect_mode)); // R4
  AST_ENTRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_hit && !detect_mode) |=> (detect_mode && mode_pulse)); // R2
  AST_RESUME_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_hit && detect_mode) |=> (!detect_mode && mode_pulse)); // R3
  AST_ENTRY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_hit && detect_mode) |=> (detect_mode && !mode_pulse)); // R5
  AST_RESUME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_hit && !detect_mode) |=> (!detect_mode && !mode_pulse)); // R6
  AST_HITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_hit, resume_hit})); // R7
endmodule

bind modesw_detector modesw_detector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .entry_hit  (entry_hit),
  .resume_hit (resume_hit),
  .detect_mode(detect_mode),
  .mode_pulse (mode_pulse)
);

// File: tb/modesw_detector_tb_top.sv
`timescale 1ns/1ps
module modesw_detector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_pin = 1'b1;
  logic le_pin = 1'b0;
  logic detect_mode;
  logic mode_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  modesw_detector dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_pin     (oe_pin),
    .le_pin     (le_pin),
    .detect_mode(detect_mode),
    .mode_pulse (mode_pulse)
  );

  // Each row is {oe, le, expected mode, expected pulse, requirement number}.
  // The expected values hold after the edge on which the row's levels are sampled.
  localparam int NV = 34;
  localparam logic [7:0] VEC [NV] = '{
    8'h87, 8'h87, 8'h87, 8'h07, 8'h87, 8'h07, 8'h87, 8'hC7, // R7 abandoned, overlapping attempt
    8'hB2,                                                 // R2 entry accepted
    8'h24,                                                 // R4 pulse gone, stale-window step
    8'hA8, 8'hA8, 8'hA8,                                   // R8 stale window must not resume
    8'hA5, 8'h25, 8'hA5, 8'hE5, 8'hA5,                     // R5 entry ignored in detection mode
    8'hA3, 8'h23, 8'hA3, 8'hA3, 8'h93,                     // R3 resume accepted
    8'h86, 8'h06, 8'h86, 8'h86, 8'h86,                     // R6 resume ignored in normal mode
    8'h89, 8'h09, 8'h89, 8'hC9, 8'hB9,                     // R9 re-entry
    8'hE4                                                  // R4 pulse gone
  };

  task automatic check(input logic act, input logic exp, input int req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic o, input logic l, input logic em, input logic ep, input int req);
    @(negedge clk);
    oe_pin = o;
    le_pin = l;
    @(posedge clk);
    #1;
    check(detect_mode, em, req, "detect_mode");
    check(mode_pulse,  ep, req, "mode_pulse");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state while reset is held
    repeat (3) @(posedge clk);
    #1;
    check(detect_mode, 1'b0, 1, "reset mode");
    check(mode_pulse,  1'b0, 1, "reset pulse");
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));
    end

    // R1: reset taken from detection mode
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(detect_mode, 1'b0, 1, "async reset mode");
    @(posedge clk);
    #1;
    check(mode_pulse, 1'b0, 1, "async reset pulse");
    @(negedge clk);
    rst_n = 1'b1;

    // R8: the tail of an entry right after reset is not enough
    step(1'b0, 1'b0, 1'b0, 1'b0, 8);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8);
    step(1'b1, 1'b1, 1'b0, 1'b0, 8);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8);
    // R2: a full entry after reset is taken
    step(1'b1, 1'b0, 1'b0, 1'b0, 2);
    step(1'b0, 1'b0, 1'b0, 1'b0, 2);
    step(1'b1, 1'b0, 1'b0, 1'b0, 2);
    step(1'b1, 1'b1, 1'b0, 1'b0, 2);
    step(1'b1, 1'b0, 1'b1, 1'b1, 2);
    step(1'b1, 1'b0, 1'b1, 1'b0, 4);

    finish_run();
  end
endmodule